// File: doc/BRIEF.md
# UART Binary Signal Monitor

This block turns a wide binary vector into a live text display on a serial terminal. It watches the vector through a synchroniser. Whenever the vector holds a value other than the one last drawn, it sends a complete screen as asynchronous serial characters. Each screen starts with a cursor-home control sequence, so every redraw lands on top of the previous one and the terminal does not scroll.

The vector is printed most significant bit first as the characters '0' and '1'. Bits are split into groups by spaces and into lines by carriage return / line feed pairs. The bit period comes from a clock-frequency parameter and a baud parameter. With the defaults of 90 MHz and 921600 baud, each bit lasts 98 clocks. Everything runs on one clock with no external serial peripheral. The block drives an active-low request-to-send line and obeys an active-low clear-to-send line. While clear-to-send is deasserted, no new character starts, but a character already on the line always finishes.

The value on screen is captured in a snapshot register when an update starts. If the inputs move during a redraw, the redraw completes with the captured value, and a fresh redraw follows at once if the inputs still differ from it.

Top module: `uart_bit_monitor`

## Requirements
- R1: `txd` is 1 while `rst_n` is low, and `txd` is 1 whenever `rts_n` is 1. `rts_n` is 1 while `rst_n` is low and whenever no update is in progress.
- R2: Every character is sent as a 0 start bit, then eight data bits least significant first, then a 1 stop bit, with no parity bit. Each bit lasts DIV = round(CLK_HZ / BAUD) clock cycles.
- R3: Exactly one screen is sent after reset is released, even when the input equals the reset value of the snapshot, which is all zeros.
- R4: A screen consists of the following characters, in this order:
  - 0x1B, 0x5B, 0x48 (cursor home).
  - The WIDTH bits from MSB to LSB, each sent as 0x30 for 0 or 0x31 for 1.
  - After every LINE-th printed bit, and after the final bit, the pair 0x0D, 0x0A.
  - After every other GROUP-th printed bit, a single 0x20.
- R5: The input passes through SYNC_STAGES (default two) flip-flop stages. A new screen starts only when the synchronised input differs from the snapshot last sent. A pulse that returns to the snapshot value before the current screen ends causes no further screen.
- R6: The snapshot is loaded when a screen starts and holds for the whole screen. If the synchronised input differs from it when the screen ends, the next screen starts immediately with the new value.
- R7: While `cts_n` is 1, no new start bit is sent and `txd` stays 1 once the character in flight has finished. When `cts_n` returns to 0, the screen resumes with no character lost.
- R8: `rts_n` is 0 from the start of a screen until the stop bit of its last character has been sent, including while transmission is paused by `cts_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| obs_in | input | WIDTH | Vector to display; may be asynchronous to `clk` |
| txd | output | 1 | Serial transmit line, 1 when idle |
| rts_n | output | 1 | Active-low request-to-send, 0 while an update is in progress |
| cts_n | input | 1 | Active-low clear-to-send; 1 holds off new characters |

## Verification
The bench decodes the serial line and compares whole screens against a bench-built model for several input patterns:
- All zeros straight after reset, which shows that the forced first screen happens.
- All ones and alternating bytes, which expose swapped characters or bit order.
- Seeded random words, which catch misplaced group and line separators.

Dedicated sequences cover the remaining cases:
- An input change in the middle of a screen tells the snapshot and the follow-on redraw apart from a corrupted mixed screen.
- A glitch that reverts before the screen ends must produce no second screen.
- A held-off clear-to-send window separates "stop between characters" from "truncate the current character".
- The bench measures low pulse widths on the line to confirm the bit period.

// File: rtl/uartmon_pkg.sv
package uartmon_pkg;

   typedef enum logic [2:0] {
      FS_IDLE,
      FS_ESC,
      FS_BRK,
      FS_HOME,
      FS_BIT,
      FS_SPACE,
      FS_CR,
      FS_LF
   } fmt_state_t;

   localparam logic [7:0] CH_ESC   = 8'h1B;
   localparam logic [7:0] CH_BRK   = 8'h5B;
   localparam logic [7:0] CH_HOME  = 8'h48;
   localparam logic [7:0] CH_ZERO  = 8'h30;
   localparam logic [7:0] CH_ONE   = 8'h31;
   localparam logic [7:0] CH_SPACE = 8'h20;
   localparam logic [7:0] CH_CR    = 8'h0D;
   localparam logic [7:0] CH_LF    = 8'h0A;

   localparam int unsigned FRAME_TAIL_BITS = 9;

endpackage

// File: rtl/uartmon_sync.sv
module uartmon_sync #(
   parameter int unsigned WIDTH  = 64,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d_in;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   assign d_out = stg[STAGES-1];

endmodule

// File: rtl/uartmon_baud.sv
module uartmon_baud #(
   parameter int unsigned DIV = 98
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic restart,
   output logic tick
);

   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (en)      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end

   assign tick = en && (cnt == LAST);

endmodule

// File: rtl/uartmon_tx.sv
module uartmon_tx import uartmon_pkg::*; #(
   parameter int unsigned DIV = 98
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cts_n,
   input  logic       valid,
   input  logic [7:0] data,
   output logic       ready,
   output logic       idle,
   output logic       tick,
   output logic       txd
);

   logic       busy;
   logic [8:0] shreg;
   logic [3:0] bits_left;
   logic       accept;

   assign ready  = !busy && !cts_n;
   assign accept = valid && ready;
   assign idle   = !busy;

   uartmon_baud #(.DIV(DIV)) baud_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (busy),
      .restart (accept),
      .tick    (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         shreg     <= '1;
         bits_left <= '0;
         txd       <= 1'b1;
      end else if (accept) begin
         busy      <= 1'b1;
         shreg     <= {1'b1, data};
         bits_left <= 4'(FRAME_TAIL_BITS);
         txd       <= 1'b0;
      end else if (tick) begin
         if (bits_left != '0) begin
            txd       <= shreg[0];
            shreg     <= {1'b1, shreg[8:1]};
            bits_left <= bits_left - 1'b1;
         end else begin
            busy <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/uartmon_fmt.sv
module uartmon_fmt import uartmon_pkg::*; #(
   parameter int unsigned WIDTH = 64,
   parameter int unsigned GROUP = 8,
   parameter int unsigned LINE  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] sample,
   input  logic             ready,
   output logic [WIDTH-1:0] snap,
   output logic             busy,
   output logic             valid,
   output logic [7:0]       data
);

   localparam int unsigned IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
   localparam int unsigned GW = (GROUP > 1) ? $clog2(GROUP) : 1;
   localparam int unsigned LW = (LINE  > 1) ? $clog2(LINE)  : 1;
   localparam logic [IW-1:0] IDX_TOP  = IW'(WIDTH - 1);
   localparam logic [GW-1:0] GRP_LAST = GW'(GROUP - 1);
   localparam logic [LW-1:0] LIN_LAST = LW'(LINE - 1);

   fmt_state_t    state;
   logic [IW-1:0] bit_idx;
   logic [GW-1:0] grp_cnt;
   logic [LW-1:0] line_cnt;
   logic          tail;
   logic          take;
   logic          last_bit;
   logic          grp_end;
   logic          line_end;

   assign busy     = (state != FS_IDLE);
   assign valid    = busy;
   assign take     = valid && ready;
   assign last_bit = (bit_idx == '0);
   assign grp_end  = (grp_cnt == GRP_LAST);
   assign line_end = (line_cnt == LIN_LAST);

   always_comb begin
      case (state)
         FS_ESC:   data = CH_ESC;
         FS_BRK:   data = CH_BRK;
         FS_HOME:  data = CH_HOME;
         FS_BIT:   data = snap[bit_idx] ? CH_ONE : CH_ZERO;
         FS_SPACE: data = CH_SPACE;
         FS_CR:    data = CH_CR;
         FS_LF:    data = CH_LF;
         default:  data = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= FS_IDLE;
         snap     <= '0;
         bit_idx  <= '0;
         grp_cnt  <= '0;
         line_cnt <= '0;
         tail     <= 1'b0;
      end else if (state == FS_IDLE) begin
         if (start) begin
            snap     <= sample;
            bit_idx  <= IDX_TOP;
            grp_cnt  <= '0;
            line_cnt <= '0;
            tail     <= 1'b0;
            state    <= FS_ESC;
         end
      end else if (take) begin
         case (state)
            FS_ESC:  state <= FS_BRK;
            FS_BRK:  state <= FS_HOME;
            FS_HOME: state <= FS_BIT;
            FS_BIT: begin
               grp_cnt  <= grp_end  ? '0 : grp_cnt + 1'b1;
               line_cnt <= line_end ? '0 : line_cnt + 1'b1;
               if (last_bit) tail <= 1'b1;
               else          bit_idx <= bit_idx - 1'b1;
               if (line_end || last_bit) state <= FS_CR;
               else if (grp_end)         state <= FS_SPACE;
               else                      state <= FS_BIT;
            end
            FS_SPACE: state <= FS_BIT;
            FS_CR:    state <= FS_LF;
            FS_LF:    state <= tail ? FS_IDLE : FS_BIT;
            default:  state <= FS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/uart_bit_monitor.sv
module uart_bit_monitor #(
   parameter int unsigned CLK_HZ      = 90_000_000,
   parameter int unsigned BAUD        = 921_600,
   parameter int unsigned WIDTH       = 64,
   parameter int unsigned GROUP       = 8,
   parameter int unsigned LINE        = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] obs_in,
   output logic             txd,
   output logic             rts_n,
   input  logic             cts_n
);

   localparam int unsigned DIV = (CLK_HZ + BAUD / 2) / BAUD;

   if (WIDTH < 2) begin : g_chk_width
      $error("uart_bit_monitor: WIDTH must be at least 2");
   end
   if (GROUP < 1 || LINE < GROUP || (LINE % GROUP) != 0) begin : g_chk_layout
      $error("uart_bit_monitor: LINE must be a positive multiple of GROUP");
   end
   if (DIV < 2) begin : g_chk_div
      $error("uart_bit_monitor: CLK_HZ / BAUD must be at least 2");
   end
   if (SYNC_STAGES < 1) begin : g_chk_sync
      $error("uart_bit_monitor: SYNC_STAGES must be at least 1");
   end

   logic [WIDTH-1:0] sync_val;
   logic [WIDTH-1:0] snap;
   logic             fmt_busy;
   logic             first_pend;
   logic             start_upd;
   logic             byte_valid;
   logic [7:0]       byte_data;
   logic             byte_ready;
   logic             tx_idle;
   logic             baud_tick;

   uartmon_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (obs_in),
      .d_out (sync_val)
   );

   assign start_upd = !fmt_busy && (first_pend || (sync_val != snap));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         first_pend <= 1'b1;
      else if (start_upd) first_pend <= 1'b0;
   end

   uartmon_fmt #(.WIDTH(WIDTH), .GROUP(GROUP), .LINE(LINE)) fmt_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start_upd),
      .sample (sync_val),
      .ready  (byte_ready),
      .snap   (snap),
      .busy   (fmt_busy),
      .valid  (byte_valid),
      .data   (byte_data)
   );

   uartmon_tx #(.DIV(DIV)) tx_i (
      .clk   (clk),
      .rst_n (rst_n),
      .cts_n (cts_n),
      .valid (byte_valid),
      .data  (byte_data),
      .ready (byte_ready),
      .idle  (tx_idle),
      .tick  (baud_tick),
      .txd   (txd)
   );

   assign rts_n = !(fmt_busy || !tx_idle);

endmodule

// File: rtl/uart_bit_monitor_chk.sv
module uart_bit_monitor_chk #(
   parameter int unsigned WIDTH = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             txd,
   input logic             rts_n,
   input logic             cts_n,
   input logic             tx_idle,
   input logic             baud_tick,
   input logic             fmt_busy,
   input logic             first_pend,
   input logic [WIDTH-1:0] sync_val,
   input logic [WIDTH-1:0] snap
);

   // R1: line stays high whenever no update is requested
   a_r1_line_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      rts_n |-> txd);

   // R2: line only changes level on a baud tick while a frame is in flight
   a_r2_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_idle && !baud_tick) |=> $stable(txd));

   // R5: no screen starts without a pending change or the forced first screen
   a_r5_no_spurious_screen: assert property (@(posedge clk) disable iff (!rst_n)
      (!fmt_busy && !first_pend && (sync_val == snap)) |=> !fmt_busy);

   // R6: snapshot does not move while a screen is being produced
   a_r6_snapshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_busy && $past(fmt_busy)) |-> $stable(snap));

   // R7: an idle transmitter does not start a frame while clear-to-send is off
   a_r7_cts_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
      (cts_n && tx_idle) |=> txd);

   // R8: a low line level always belongs to an update in progress
   a_r8_rts_covers_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !txd |-> !rts_n);

endmodule

bind uart_bit_monitor uart_bit_monitor_chk #(.WIDTH(WIDTH)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .txd        (txd),
   .rts_n      (rts_n),
   .cts_n      (cts_n),
   .tx_idle    (tx_idle),
   .baud_tick  (baud_tick),
   .fmt_busy   (fmt_busy),
   .first_pend (first_pend),
   .sync_val   (sync_val),
   .snap       (snap)
);

// File: tb/uart_bit_monitor_tb_top.sv
module uart_bit_monitor_tb_top;

   localparam int W   = 64;
   localparam int DIV = 4;
   localparam int SCR = 77;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] obs = '0;
   logic         cts_n = 1'b0;
   logic         txd;
   logic         rts_n;

   int checks = 0;
   int errors = 0;
   int start_bad = 0;
   int stop_bad = 0;
   int run_bad = 0;
   int run_len = 0;
   bit seen_unit = 1'b0;
   logic [7:0] rx_q[$];
   logic [7:0] exp_q[$];

   always #10 clk = ~clk;

   uart_bit_monitor #(
      .CLK_HZ(50_000_000), .BAUD(12_500_000), .WIDTH(W),
      .GROUP(8), .LINE(32), .SYNC_STAGES(2)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .obs_in(obs),
      .txd(txd), .rts_n(rts_n), .cts_n(cts_n)
   );

   // serial decoder, samples mid-bit on falling edges
   initial begin
      logic [7:0] b;
      forever begin
         @(negedge clk);
         if (rst_n && txd === 1'b0) begin
            repeat (DIV / 2) @(negedge clk);
            if (txd !== 1'b0) start_bad++;
            for (int k = 0; k < 8; k++) begin
               repeat (DIV) @(negedge clk);
               b[k] = txd;
            end
            repeat (DIV) @(negedge clk);
            if (txd !== 1'b1) stop_bad++;
            rx_q.push_back(b);
         end
      end
   end

   // low pulse widths must be whole bit periods
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && txd === 1'b0) run_len++;
         else if (run_len > 0) begin
            if (run_len % DIV != 0) run_bad++;
            if (run_len == DIV) seen_unit = 1'b1;
            run_len = 0;
         end
      end
   end

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic build_screen(input logic [W-1:0] v);
      exp_q.delete();
      exp_q.push_back(8'h1B); exp_q.push_back(8'h5B); exp_q.push_back(8'h48);
      for (int i = W - 1; i >= 0; i--) begin
         int p;
         p = W - i;
         exp_q.push_back(v[i] ? 8'h31 : 8'h30);
         if (p % 32 == 0 || i == 0) begin
            exp_q.push_back(8'h0D); exp_q.push_back(8'h0A);
         end else if (p % 8 == 0) begin
            exp_q.push_back(8'h20);
         end
      end
   endtask

   task automatic check_screen(input int base, input logic [W-1:0] v, input string req);
      int bad_at;
      build_screen(v);
      bad_at = -1;
      for (int i = 0; i < exp_q.size(); i++) begin
         if (bad_at < 0 && (base + i >= rx_q.size() || rx_q[base + i] !== exp_q[i]))
            bad_at = i;
      end
      if (bad_at < 0)
         check(1'b1, req, "screen", 0, 0);
      else if (base + bad_at >= rx_q.size())
         check(1'b0, req, "screen length", rx_q.size() - base, exp_q.size());
      else
         check(1'b0, req, $sformatf("screen char %0d", bad_at),
               rx_q[base + bad_at], exp_q[bad_at]);
   endtask

   task automatic wait_bytes(input int n);
      while (rx_q.size() < n) @(negedge clk);
   endtask

   task automatic show(input logic [W-1:0] v, input string req);
      int base;
      base = rx_q.size();
      @(negedge clk);
      obs = v;
      wait_bytes(base + SCR);
      check_screen(base, v, req);
      repeat (20) @(negedge clk);
   endtask

   initial begin
      int base;
      int n1;
      int hold_bad;
      logic [W-1:0] va;
      logic [W-1:0] vb;
      void'($urandom(32'h5EED_0042));

      repeat (5) @(negedge clk);
      check(txd === 1'b1, "R1", "txd in reset", txd, 1);
      check(rts_n === 1'b1, "R1", "rts_n in reset", rts_n, 1);
      rst_n = 1'b1;

      // R3 and R4: forced first screen of an all-zero input
      wait_bytes(SCR);
      check_screen(0, '0, "R3");
      repeat (10) @(negedge clk);
      check(rts_n === 1'b1 && txd === 1'b1, "R1", "idle after screen",
            {rts_n, txd}, 2'b11);

      // R5: no change, no traffic
      repeat (600) @(negedge clk);
      check(rx_q.size() == SCR, "R5", "quiet when unchanged", rx_q.size(), SCR);

      // R8: rts_n low mid-screen; R4 all ones
      base = rx_q.size();
      obs = '1;
      wait_bytes(base + 5);
      check(rts_n === 1'b0, "R8", "rts_n during screen", rts_n, 0);
      wait_bytes(base + SCR);
      check_screen(base, '1, "R4");
      repeat (20) @(negedge clk);

      show(64'hA55A_F00F_0123_89AB, "R4");
      for (int r = 0; r < 4; r++) show({$urandom, $urandom}, "R4");

      // R5: glitch that reverts before the screen ends
      va = {$urandom, $urandom};
      base = rx_q.size();
      obs = va;
      wait_bytes(base + 10);
      obs = va ^ 64'h1;
      repeat (30) @(negedge clk);
      obs = va;
      wait_bytes(base + SCR);
      check_screen(base, va, "R5");
      repeat (800) @(negedge clk);
      check(rx_q.size() == base + SCR, "R5", "no redraw after reverted glitch",
            rx_q.size() - base, SCR);

      // R6: change mid-screen gives old screen then new one
      va = {$urandom, $urandom};
      vb = ~va;
      base = rx_q.size();
      obs = va;
      wait_bytes(base + 10);
      obs = vb;
      wait_bytes(base + 2 * SCR);
      check_screen(base, va, "R6");
      check_screen(base + SCR, vb, "R6");
      repeat (20) @(negedge clk);

      // R7: clear-to-send hold-off
      va = {$urandom, $urandom};
      base = rx_q.size();
      obs = va;
      wait_bytes(base + 20);
      cts_n = 1'b1;
      repeat (100) @(negedge clk);
      n1 = rx_q.size();
      check(n1 <= base + 21, "R7", "chars after cts_n high", n1 - base, 21);
      hold_bad = 0;
      for (int t = 0; t < 200; t++) begin
         @(negedge clk);
         if (txd !== 1'b1) hold_bad++;
      end
      check(hold_bad == 0 && rx_q.size() == n1, "R7", "line held idle",
            hold_bad, 0);
      check(rts_n === 1'b0, "R8", "rts_n while paused", rts_n, 0);
      cts_n = 1'b0;
      wait_bytes(base + SCR);
      check_screen(base, va, "R7");
      repeat (50) @(negedge clk);

      // R2: frame shape and bit period
      check(start_bad == 0, "R2", "start bits", start_bad, 0);
      check(stop_bad == 0, "R2", "stop bits", stop_bad, 0);
      check(run_bad == 0, "R2", "low runs not whole bits", run_bad, 0);
      check(seen_unit, "R2", "single bit period seen", seen_unit, 1);

      summary();
      $finish;
   end

endmodule